// File: doc/BRIEF.md
# Gain and Fractional-Delay Corrector

This block sits on the output of one sub-converter in a two-way time-interleaved ADC and applies the correction values that a separate estimator has computed. Each sample is first scaled by an unsigned gain word. It then passes through a first-order fractional-delay stage. That stage adds to the window's centre sample a signed fraction of a local derivative estimate, which moves the sample in time by less than one sample period. The whole path runs at the sub-converter rate and handles one sample per clock when the valid strobe is high.

The delay stage has two branches. One branch is a plain delay to the centre tap. The other is a short antisymmetric differentiator whose taps are folded, so that each coefficient needs one multiplier. A single multiplier by the timing word then combines the two branches. A valid strobe travels with the data through a fixed five-cycle pipeline. A bypass control sends raw samples down the same pipeline, so that a channel left uncorrected stays aligned in time with its corrected partner.

Top module: `skew_gain_corrector`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `out_data` are both 0.
- R2: Each input sample taken with `in_valid` high produces exactly one output with `out_valid` high, 5 clock cycles later. No other cycle has `out_valid` high.
- R3: Outside bypass, each sample x is scaled by `gain_word` read as unsigned Q1.15. The result is floor((x*gain + 16384) / 32768), so 0x8000 returns x unchanged.
- R4: The scaled sample is saturated to the signed 14-bit range −8192..8191.
- R5: A window holds the five most recent scaled samples, with s0 the newest and s4 the oldest. The derivative term is D = floor((683*(s1−s3) − 85*(s0−s4)) / 1024).
- R6: Outside bypass, the output is s2 + floor((D*t + 1024) / 2048). Here t is `skew_word` read as signed 12-bit, so t = 0 returns s2 exactly.
- R7: The sum in R6 is saturated to the signed 14-bit range.
- R8: With `bypass` high, the sample enters the window unscaled and the output is s2 unchanged, with the same 5-cycle latency. `gain_word` and `skew_word` have no effect on it.
- R9: The window advances only on valid samples. Between valid outputs, `out_data` holds its last value.
- R10: After reset the window holds zeros, so the first two outputs after reset equal the centre tap's reset value of 0.
- R11: `gain_word`, `skew_word` and `bypass` are captured together with the sample they arrive with. The output uses the skew and bypass values of the newest sample in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-converter sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Signed input sample |
| gain_word | input | 16 | Unsigned Q1.15 gain factor |
| skew_word | input | 12 | Signed fractional delay, LSB = 1/2048 sample |
| bypass | input | 1 | Pass raw samples with matching latency |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 14 | Signed corrected sample |

## Verification
The bench aims at both saturation points. A large gain applied to full-scale inputs hits the first. A full-scale step under maximum skew hits the second, which drives the centre-plus-correction sum past full scale. A design that wraps instead of clamping would output samples of the opposite sign. The bench also feeds samples with idle gaps between them. A window that shifts on every clock would then fill with stale samples and produce wrong derivatives, and an output register that is not held would show changes between strobes. The bench also uses negative skew, the two outputs just after reset, and bypass with extreme gain and skew words. A design that rounds the wrong way, ignores the reset contents of the window, or lets gain leak into bypass would differ from the model by one or more LSBs.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    localparam int DATA_W   = 14;
    localparam int GAIN_W   = 16;
    localparam int TIME_W   = 12;
    localparam int COEF_W   = 12;
    localparam int WIDE_W   = 48;
    localparam int PIPE_LAT = 5;

    typedef logic signed [DATA_W-1:0] samp_t;

    typedef struct packed {
        logic              vld;
        logic              byp;
        logic [TIME_W-1:0] tim;
    } ctl_t;

    localparam logic signed [WIDE_W-1:0] SAT_HI = WIDE_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
    localparam logic signed [WIDE_W-1:0] SAT_LO = WIDE_W'(-(64'sd1 <<< (DATA_W-1)));

    // Differentiator coefficient for folded pair j (pair j spans taps HALF-j and HALF+j)
    function automatic logic signed [COEF_W-1:0] diff_coef(input int j);
        case (j)
            1:       return COEF_W'(683);
            2:       return COEF_W'(-85);
            default: return '0;
        endcase
    endfunction

    function automatic samp_t sat_samp(input logic signed [WIDE_W-1:0] v);
        if (v > SAT_HI) return samp_t'(SAT_HI);
        if (v < SAT_LO) return samp_t'(SAT_LO);
        return samp_t'(v);
    endfunction

endpackage

// File: rtl/sgc_gain_stage.sv
module sgc_gain_stage
    import sgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_bypass,
    input  samp_t             in_data,
    input  logic [GAIN_W-1:0] gain,
    input  logic [TIME_W-1:0] in_time,
    output samp_t             out_data,
    output ctl_t              out_ctl
);
    localparam int PW = DATA_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] GRND = PW'(1) <<< (GAIN_W-2);
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W-1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    samp_t                scaled;

    always_comb begin
        prod    = PW'(in_data) * PW'($signed({1'b0, gain}));
        shifted = (prod + GRND) >>> (GAIN_W-1);
        scaled  = sat_samp(WIDE_W'(shifted));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_ctl  <= '0;
        end else begin
            out_ctl.vld <= in_valid;
            if (in_valid) begin
                out_data    <= in_bypass ? in_data : scaled;
                out_ctl.byp <= in_bypass;
                out_ctl.tim <= in_time;
            end
        end
    end

    AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_bypass && gain == UNITY) |=> (out_data == $past(in_data))); // R3

    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bypass) |=> (out_data == $past(in_data))); // R8

endmodule

// File: rtl/sgc_fold_stage.sv
module sgc_fold_stage
    import sgc_pkg::*;
#(
    parameter int HALF  = 2,
    parameter int SUM_W = DATA_W + 1 + COEF_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  samp_t                   in_data,
    input  ctl_t                    in_ctl,
    output samp_t                   center,
    output logic signed [SUM_W-1:0] dsum,
    output ctl_t                    out_ctl
);
    localparam int NTAP = 2*HALF + 1;
    localparam int DF_W = DATA_W + 1;
    localparam int PR_W = DF_W + COEF_W;

    samp_t                   taps   [NTAP];
    logic signed [PR_W-1:0]  prod_q [HALF];
    ctl_t                    ctl_a;

    // Window: taps[0] newest; shifts only on a valid sample
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAP; i++) taps[i] <= '0;
            ctl_a <= '0;
        end else begin
            ctl_a <= in_ctl;
            if (in_ctl.vld) begin
                taps[0] <= in_data;
                for (int i = 1; i < NTAP; i++) taps[i] <= taps[i-1];
            end
        end
    end

    // Folded antisymmetric pairs: one multiplier per coefficient
    for (genvar j = 1; j <= HALF; j++) begin : g_pair
        logic signed [DF_W-1:0] fold;
        assign fold = DF_W'(taps[HALF-j]) - DF_W'(taps[HALF+j]);
        always_ff @(posedge clk) begin
            if (rst) prod_q[j-1] <= '0;
            else     prod_q[j-1] <= PR_W'(fold) * PR_W'(diff_coef(j));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            center  <= '0;
            out_ctl <= '0;
        end else begin
            center  <= taps[HALF];
            out_ctl <= ctl_a;
        end
    end

    always_comb begin
        dsum = '0;
        for (int j = 0; j < HALF; j++) dsum = dsum + SUM_W'(prod_q[j]);
    end

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_ctl.vld |=> ($stable(taps[0]) && $stable(taps[NTAP-1]))); // R9

endmodule

// File: rtl/sgc_farrow_out.sv
module sgc_farrow_out
    import sgc_pkg::*;
#(
    parameter int SUM_W   = DATA_W + 1 + COEF_W + 2,
    parameter int COEF_SH = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  samp_t                   center,
    input  logic signed [SUM_W-1:0] dsum,
    input  ctl_t                    in_ctl,
    output logic                    out_valid,
    output samp_t                   out_data
);
    localparam int M_W = SUM_W + TIME_W;
    localparam logic signed [WIDE_W-1:0] TRND = WIDE_W'(1) <<< (TIME_W-2);

    logic signed [SUM_W-1:0]  der;
    logic signed [M_W-1:0]    m_q;
    samp_t                    center_c;
    ctl_t                     ctl_c;
    logic signed [WIDE_W-1:0] corr;
    logic signed [WIDE_W-1:0] ysum;

    assign der = dsum >>> COEF_SH;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q      <= '0;
            center_c <= '0;
            ctl_c    <= '0;
        end else begin
            m_q      <= M_W'(der) * M_W'($signed(in_ctl.tim));
            center_c <= center;
            ctl_c    <= in_ctl;
        end
    end

    always_comb begin
        corr = (WIDE_W'(m_q) + TRND) >>> (TIME_W-1);
        ysum = WIDE_W'(center_c) + corr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl_c.vld;
            if (ctl_c.vld) out_data <= ctl_c.byp ? center_c : sat_samp(ysum);
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctl_c.vld |=> $stable(out_data)); // R9

    AST_ZERO_SKEW: assert property (@(posedge clk) disable iff (rst)
        (ctl_c.vld && ctl_c.tim == '0) |=> (out_data == $past(center_c))); // R6

    AST_BYPASS_CENTER: assert property (@(posedge clk) disable iff (rst)
        (ctl_c.vld && ctl_c.byp) |=> (out_data == $past(center_c))); // R8

endmodule

// File: rtl/skew_gain_corrector.sv
module skew_gain_corrector
    import sgc_pkg::*;
#(
    parameter int HALF    = 2,
    parameter int COEF_SH = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [GAIN_W-1:0] gain_word,
    input  logic [TIME_W-1:0] skew_word,
    input  logic              bypass,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int SUM_W = DATA_W + 1 + COEF_W + $clog2(HALF) + 1;
    localparam int WRM_W = $clog2(PIPE_LAT + 1);

    samp_t                   g_data;
    ctl_t                    g_ctl;
    samp_t                   f_center;
    logic signed [SUM_W-1:0] f_dsum;
    ctl_t                    f_ctl;
    samp_t                   y_data;

    sgc_gain_stage u_gain (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bypass (bypass),
        .in_data   (samp_t'(in_data)),
        .gain      (gain_word),
        .in_time   (skew_word),
        .out_data  (g_data),
        .out_ctl   (g_ctl)
    );

    sgc_fold_stage #(.HALF(HALF), .SUM_W(SUM_W)) u_fold (
        .clk     (clk),
        .rst     (rst),
        .in_data (g_data),
        .in_ctl  (g_ctl),
        .center  (f_center),
        .dsum    (f_dsum),
        .out_ctl (f_ctl)
    );

    sgc_farrow_out #(.SUM_W(SUM_W), .COEF_SH(COEF_SH)) u_farrow (
        .clk       (clk),
        .rst       (rst),
        .center    (f_center),
        .dsum      (f_dsum),
        .in_ctl    (f_ctl),
        .out_valid (out_valid),
        .out_data  (y_data)
    );

    assign out_data = y_data;

    // Cycles since reset, for the latency property
    logic [WRM_W-1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                             warm <= '0;
        else if (warm != WRM_W'(PIPE_LAT))   warm <= warm + 1'b1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == WRM_W'(PIPE_LAT)) |-> (out_valid == $past(in_valid, PIPE_LAT))); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0)); // R1

endmodule

// File: tb/skew_gain_corrector_bench.sv
module skew_gain_corrector_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [13:0] in_data = '0;
    logic [15:0] gain_word = 16'h8000;
    logic [11:0] skew_word = '0;
    logic        bypass = 1'b0;
    logic        out_valid;
    logic [13:0] out_data;

    always #2 clk = ~clk;   // 250 MHz

    skew_gain_corrector u_skew_gain_corrector (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .gain_word (gain_word),
        .skew_word (skew_word),
        .bypass    (bypass),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct {
        longint data;
        int     cyc;
        string  req;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc = 0;
    longint hist[5];
    bit     seen_out = 0;
    longint last_out = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint sat14(input longint v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    // Driver: applies one sample and pushes the model's expected output
    task automatic send(input longint x, input int g, input int d, input bit byp, input string req);
        longint sc, der, corr, y;
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 14'(x);
        gain_word = 16'(g);
        skew_word = 12'(d);
        bypass    = byp;
        if (byp) sc = x;
        else     sc = sat14((x * longint'(g) + 16384) >>> 15);      // R3 R4
        for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = sc;
        der  = (683 * (hist[1] - hist[3]) - 85 * (hist[0] - hist[4])) >>> 10;  // R5
        corr = (der * longint'(d) + 1024) >>> 11;                               // R6
        y    = byp ? hist[2] : sat14(hist[2] + corr);                           // R7 R8
        e.data = y;
        e.cyc  = cyc + 5;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 14'h2AAA;
        end
    endtask

    task automatic drain();
        idle(1);
        while (sb.size() != 0) idle(1);
        idle(3);
    endtask

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R2: unexpected out_valid got 1 expected 0 at cycle %0d", cyc);
                end else begin
                    exp_t e;
                    longint got;
                    e   = sb.pop_front();
                    got = longint'($signed(out_data));
                    n_chk++;
                    if (got != e.data) begin
                        n_bad++;
                        $display("FAIL %s: out_data got %0d expected %0d", e.req, got, e.data);
                    end
                    n_chk++;
                    if (cyc != e.cyc) begin
                        n_bad++;
                        $display("FAIL R2: output cycle got %0d expected %0d", cyc, e.cyc);
                    end
                    seen_out = 1;
                    last_out = got;
                end
            end else if (seen_out) begin
                n_chk++;
                if (longint'($signed(out_data)) != last_out) begin
                    n_bad++;
                    $display("FAIL R9: idle out_data got %0d expected %0d",
                             longint'($signed(out_data)), last_out);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 5; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R1: in reset got valid=%0b data=%0d expected 0/0", out_valid, out_data);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R1: after reset got valid=%0b data=%0d expected 0/0", out_valid, out_data);
        end

        // R10 then R3: unity gain, zero skew, window starts at zero
        for (int i = 0; i < 8; i++) send(100 * (i + 1), 16'h8000, 0, 1'b0, (i < 2) ? "R10" : "R3");
        drain();

        // R3: fractional gain
        for (int i = 0; i < 12; i++) send(((i * 1237) % 8000) - 4000, 16'h6000, 0, 1'b0, "R3");
        drain();

        // R4: gain near 2 on large samples saturates
        for (int i = 0; i < 10; i++)
            send((i % 2 == 0) ? (6000 + i * 100) : -(6000 + i * 100), 16'hFFFF, 0, 1'b0, "R4");
        drain();

        // R5 R6: derivative path with positive and negative skew
        for (int i = 0; i < 12; i++) send(((i * i * 37) % 6000) - 3000, 16'h8000, 1024, 1'b0, "R5");
        for (int i = 0; i < 12; i++) send((i * 523) - 3000, 16'h8000, -2048, 1'b0, "R6");
        for (int i = 0; i < 10; i++) send(((i * 911) % 5000) - 2500, 16'h7400, 333, 1'b0, "R6");
        drain();

        // R7: full-scale step under maximum skew saturates the final sum
        send(-8192, 16'h8000, 2047, 1'b0, "R7");
        send(-8192, 16'h8000, 2047, 1'b0, "R7");
        for (int i = 0; i < 3; i++) send(8191, 16'h8000, 2047, 1'b0, "R7");
        for (int i = 0; i < 3; i++) send(-8192, 16'h8000, 2047, 1'b0, "R7");
        for (int i = 0; i < 3; i++) send(8191, 16'h8000, -2048, 1'b0, "R7");
        drain();

        // R8: bypass ignores extreme gain and skew
        for (int i = 0; i < 10; i++) send((i * 1700) - 8000, 16'hFFFF, 2047, 1'b1, "R8");
        drain();

        // R11: controls change sample by sample
        for (int i = 0; i < 10; i++)
            send((i * 777) - 3500, (i % 2) ? 16'h9000 : 16'h7000, (i % 3) * 500 - 500, (i % 4 == 3), "R11");
        drain();

        // R9: idle gaps between samples
        for (int i = 0; i < 14; i++) begin
            send(((i * 1311) % 7000) - 3500, 16'h7000, -700, 1'b0, "R9");
            idle(1 + (i % 3));
        end
        drain();

        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: pending outputs got %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule